// File: doc/BRIEF.md
# ROM-over-RAM Memory Decoder

This block sits between a CPU with a 16-bit byte address bus and three data sources: a full 64KB RAM, a ROM laid over the top half of that RAM, and a small window of memory-mapped control registers. Every CPU write goes to the RAM underneath, including writes to addresses where ROM is currently visible. The only exception is a write into the register window. Reads in the overlaid range return ROM data or the hidden RAM data, according to a visibility flag. The CPU sets that flag by writing to one strobe address and clears it by writing to another.

The decoder produces two signals in the address phase: the RAM write enable and the register-window select. These are combinational from the address and direction. For a read, it also latches a one-hot source select on the address-phase clock edge. In the following cycle (the data phase), the read-data multiplexer uses that latched select to route the ROM, RAM or register data back to the CPU. As a result, reads and writes at the same overlaid address reach different devices. Software can use the RAM under the ROM as a write-mostly log buffer and pay the cost of reading it back only when it needs to.

Top module: `mem_overlay_dec`

## Requirements
- R1: A valid write to any address outside 0xFD00–0xFF3F asserts `ram_we_o` in the same cycle, whatever the ROM visibility. This includes the overlaid ranges 0x8000–0xFCFF and 0xFF40–0xFFFF.
- R2: A valid access of either direction inside 0xFD00–0xFF3F asserts `reg_sel_o` in the same cycle and never asserts `ram_we_o`. `reg_sel_o` is low for every other address, and whenever `valid_i` is low.
- R3: A valid read in 0x8000–0xFCFF or 0xFF40–0xFFFF with ROM visible returns `rom_rdata_i` on `rdata_o` in the next cycle.
- R4: The same read with ROM hidden returns `ram_rdata_i` in the next cycle.
- R5: A valid read in 0x0000–0x7FFF returns `ram_rdata_i` in the next cycle, whatever the visibility.
- R6: A valid read inside 0xFD00–0xFF3F returns `reg_rdata_i` in the next cycle.
- R7: A valid write to 0xFF3E makes ROM visible from the next cycle. A valid write to 0xFF3F hides it from the next cycle. A read of either address leaves visibility unchanged.
- R8: While `rst_ni` is low, `rdata_o` is zero. After reset, ROM is visible.
- R9: The source of a read is fixed on its address-phase edge. A visibility strobe write issued in the cycle right after a read does not change the data that read returns.
- R10: In a cycle that follows a cycle with no valid read, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Bus cycle active this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU byte address |
| rom_rdata_i | input | 8 | ROM read data (data phase) |
| ram_rdata_i | input | 8 | RAM read data (data phase) |
| reg_rdata_i | input | 8 | Control-register read data (data phase) |
| ram_we_o | output | 1 | RAM write enable (address phase) |
| reg_sel_o | output | 1 | Register-window select (address phase) |
| rdata_o | output | 8 | Read data to CPU (data phase) |

## Verification
A read's data phase and the address phase of the next access share one cycle. When that next access is a visibility strobe write, the mode change and the routing of the earlier read meet in the same cycle. The bench provokes this by issuing a read of an overlaid address and following it immediately with a write to 0xFF3E or 0xFF3F, in both directions. A cycle-level reference model then judges the result: the returned byte must come from the source chosen under the old mode, and the next read must see the new mode. Randomized traffic biased toward the strobe and window-boundary addresses repeats the overlap many more times.

// File: rtl/mem_overlay_pkg.sv
package mem_overlay_pkg;
  // one-hot read source, latched on the address phase
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_ROM  = 3'b001,
    SRC_RAM  = 3'b010,
    SRC_REG  = 3'b100
  } src_e;
endpackage

// File: rtl/ovl_addr_map.sv
module ovl_addr_map #(
  parameter int          AW           = 16,
  parameter logic [15:0] ROM_LO       = 16'h8000,
  parameter logic [15:0] WIN_LO       = 16'hFD00,
  parameter logic [15:0] WIN_HI       = 16'hFF3F,
  parameter logic [15:0] VIS_ON_ADDR  = 16'hFF3E,
  parameter logic [15:0] VIS_OFF_ADDR = 16'hFF3F
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_win_o,
  output logic          in_ovl_o,
  output logic          hit_on_o,
  output logic          hit_off_o
);
  localparam logic [AW-1:0] RomLo = AW'(ROM_LO);
  localparam logic [AW-1:0] WinLo = AW'(WIN_LO);
  localparam logic [AW-1:0] WinHi = AW'(WIN_HI);

  always_comb begin
    in_win_o  = (addr_i >= WinLo) && (addr_i <= WinHi);
    in_ovl_o  = (addr_i >= RomLo) && !in_win_o;
    hit_on_o  = addr_i == AW'(VIS_ON_ADDR);
    hit_off_o = addr_i == AW'(VIS_OFF_ADDR);
  end
endmodule

// File: rtl/ovl_vis_ctrl.sv
module ovl_vis_ctrl #(
  parameter bit VIS_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic vis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vis_o <= VIS_RST;
    else if (set_i) vis_o <= 1'b1;
    else if (clr_i) vis_o <= 1'b0;
  end

  // R7
  vis_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> vis_o);
  // R7
  vis_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !vis_o);
endmodule

// File: rtl/ovl_rd_path.sv
module ovl_rd_path
  import mem_overlay_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          in_win_i,
  input  logic          in_ovl_i,
  input  logic          vis_i,
  input  logic [DW-1:0] rom_rdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] rdata_o
);
  src_e src_d, src_q;

  always_comb begin
    src_d = SRC_NONE;
    if (rd_i) begin
      if (in_win_i)                src_d = SRC_REG;
      else if (in_ovl_i && vis_i)  src_d = SRC_ROM;
      else                         src_d = SRC_RAM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_NONE;
    else         src_q <= src_d;
  end

  always_comb begin
    unique case (src_q)
      SRC_ROM: rdata_o = rom_rdata_i;
      SRC_RAM: rdata_o = ram_rdata_i;
      SRC_REG: rdata_o = reg_rdata_i;
      default: rdata_o = '0;
    endcase
  end

  // R9
  src_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_q));
  // R6
  reg_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_win_i) |=> (rdata_o == reg_rdata_i));
  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

// File: rtl/mem_overlay_dec.sv
module mem_overlay_dec
  import mem_overlay_pkg::*;
#(
  parameter int          AW           = 16,
  parameter int          DW           = 8,
  parameter logic [15:0] ROM_LO       = 16'h8000,
  parameter logic [15:0] WIN_LO       = 16'hFD00,
  parameter logic [15:0] WIN_HI       = 16'hFF3F,
  parameter logic [15:0] VIS_ON_ADDR  = 16'hFF3E,
  parameter logic [15:0] VIS_OFF_ADDR = 16'hFF3F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rom_rdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          ram_we_o,
  output logic          reg_sel_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] WinLo = AW'(WIN_LO);
  localparam logic [AW-1:0] WinHi = AW'(WIN_HI);
  localparam logic [AW-1:0] RomLo = AW'(ROM_LO);

  logic in_win, in_ovl, hit_on, hit_off, vis;
  logic wr, rd;

  assign wr = valid_i && we_i;
  assign rd = valid_i && !we_i;

  ovl_addr_map #(
    .AW(AW), .ROM_LO(ROM_LO), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .VIS_ON_ADDR(VIS_ON_ADDR), .VIS_OFF_ADDR(VIS_OFF_ADDR)
  ) u_map (
    .addr_i   (addr_i),
    .in_win_o (in_win),
    .in_ovl_o (in_ovl),
    .hit_on_o (hit_on),
    .hit_off_o(hit_off)
  );

  ovl_vis_ctrl #(.VIS_RST(1'b1)) u_vis (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wr && hit_on),
    .clr_i (wr && hit_off),
    .vis_o (vis)
  );

  ovl_rd_path #(.DW(DW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd),
    .in_win_i   (in_win),
    .in_ovl_i   (in_ovl),
    .vis_i      (vis),
    .rom_rdata_i(rom_rdata_i),
    .ram_rdata_i(ram_rdata_i),
    .reg_rdata_i(reg_rdata_i),
    .rdata_o    (rdata_o)
  );

  // writes fall through to RAM regardless of ROM visibility
  assign ram_we_o  = wr && !in_win;
  assign reg_sel_o = valid_i && in_win;

  // R1
  wr_fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && we_i && ((addr_i < WinLo) || (addr_i > WinHi))) |-> ram_we_o);
  // R2
  win_no_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i >= WinLo) && (addr_i <= WinHi)) |-> !ram_we_o);
  // R2
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && reg_sel_o));
  // R5
  low_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !we_i && (addr_i < RomLo)) |=> (rdata_o == ram_rdata_i));
endmodule

// File: tb/mem_overlay_dec_tb.sv
`timescale 1ns/1ps
module mem_overlay_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  rom_d = '0, ram_d = '0, reg_d = '0;
  logic        ram_we, reg_sel;
  logic [7:0]  rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_vis = 1;
  int m_src = 0;  // 0 none, 1 rom, 2 ram-hidden, 3 ram-low, 4 reg

  always #2.5 clk = ~clk;

  mem_overlay_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .we_i(we), .addr_i(addr),
    .rom_rdata_i(rom_d), .ram_rdata_i(ram_d), .reg_rdata_i(reg_d),
    .ram_we_o(ram_we), .reg_sel_o(reg_sel), .rdata_o(rdata)
  );

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'hFD00 && a <= 16'hFF3F;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [15:0] a);
    int exp_rd;
    string tg;
    @(negedge clk);
    valid = v; we = w; addr = a;
    rom_d = 8'($urandom); ram_d = 8'($urandom); reg_d = 8'($urandom);
    #1;
    cmp((v && w && !in_win(a)) ? "R1" : "R2", ram_we, v && w && !in_win(a));
    cmp("R2", reg_sel, v && in_win(a));
    case (m_src)
      1: begin exp_rd = rom_d; tg = "R3"; end
      2: begin exp_rd = ram_d; tg = "R4"; end
      3: begin exp_rd = ram_d; tg = "R5"; end
      4: begin exp_rd = reg_d; tg = "R6"; end
      default: begin exp_rd = 0; tg = "R10"; end
    endcase
    cmp(tg, rdata, exp_rd);
    // model update at the coming edge (R9: source fixed with the old mode)
    if (v && !w) begin
      if (in_win(a))            m_src = 4;
      else if (a < 16'h8000)    m_src = 3;
      else                      m_src = m_vis ? 1 : 2;
    end else m_src = 0;
    if (v && w && a == 16'hFF3E) m_vis = 1;  // R7
    if (v && w && a == 16'hFF3F) m_vis = 0;  // R7
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    rom_d = 8'h5A; ram_d = 8'hA5; reg_d = 8'h3C; valid = 1'b1; we = 1'b0; addr = 16'h9000;
    #1;
    cmp("R8", rdata, 0);
    cmp("R8", ram_we, 0);
    valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R8 ROM visible after reset; R3/R5 reads
    step(1, 0, 16'h9000);
    step(1, 0, 16'hFF50);
    step(1, 0, 16'h1001);
    step(1, 0, 16'hFCFF);
    // R1 writes fall through
    step(1, 1, 16'hA000);
    step(1, 1, 16'hFF40);
    step(1, 1, 16'hFFFF);
    step(1, 1, 16'h0000);
    step(1, 1, 16'hFCFF);
    // R2/R6 window edges
    step(1, 1, 16'hFD00);
    step(1, 0, 16'hFD00);
    step(1, 0, 16'hFE80);
    step(1, 1, 16'hFF3D);
    step(1, 0, 16'hFF3D);
    // R7 reads of strobes do nothing
    step(1, 0, 16'hFF3F);
    step(1, 0, 16'hC000);
    // R7 hide, R4 reads
    step(1, 1, 16'hFF3F);
    step(1, 0, 16'hC000);
    step(1, 0, 16'hFFFC);
    step(1, 0, 16'h7FFF);
    step(1, 0, 16'hFF3E);
    step(1, 0, 16'h8000);
    // R9 overlap: read then strobe write next cycle
    step(1, 1, 16'hFF3E);
    step(1, 0, 16'hC000);
    step(1, 1, 16'hFF3F);
    step(1, 0, 16'hC000);
    step(1, 1, 16'hFF3E);
    step(1, 0, 16'hC000);
    // R10 idle
    step(0, 0, 16'h9000);
    step(0, 1, 16'hFD10);
    step(0, 0, 16'h0000);
    // random traffic biased to corners
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom % 8)
        0: a = 16'hFF3E;
        1: a = 16'hFF3F;
        2: a = 16'hFCFF;
        3: a = 16'hFF40;
        4: a = 16'hFD00;
        5: a = 16'h8000 + 16'($urandom % 16'h7D00);
        default: a = 16'($urandom);
      endcase
      step(($urandom % 5) != 0, $urandom % 2, a);
    end
    step(0, 0, 16'h0000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule